// File: doc/BRIEF.md
# Scanline and Frame Interrupt Timer

This block stands in for the timing of a scanned display. It watches a free-running tick count and measures a line period against it. The line period is the programmed frame length in ticks divided by the programmed number of lines. Each time a full line period has gone by since the previous line event, the block raises a one-cycle line interrupt and steps its current-line counter. When the count reaches the programmed height, the counter returns to zero. In that same cycle a one-cycle frame (vertical blank) interrupt is raised.

Software programs the frame length and the height together with a single write strobe. The division runs once per write on a shift-subtract divider, so no divider sits in the per-cycle compare path. Line events are held off while the division runs. When it completes, the last-event timestamp is re-armed to the tick count of that cycle. The current line is a registered output that can be read back at any time.

Top module: `scan_irq_timer`

## Requirements
- R1: While `rst_n` is low on a clock edge, the current line becomes 0, both interrupts become 0, the height becomes `DEF_HEIGHT` (400), the line period becomes `DEF_FRAME_TICKS / DEF_HEIGHT`, and the last-event timestamp takes the value of `tick_i`.
- R2: On an edge where no divide is in progress and the height is non-zero, a line event occurs if `(tick_i - timestamp) mod 2^TICK_W >= period`. After that edge, `line_irq_o` is 1 for exactly one cycle.
- R3: On a line event, `cur_line_o` increments by 1 and the timestamp takes the `tick_i` value of that edge.
- R4: On a line event where the incremented line would be at least the height, `cur_line_o` goes to 0 instead. `frame_irq_o` then pulses in the same cycle as `line_irq_o`.
- R5: An edge with `cfg_we` high stores `cfg_height` and clears `cur_line_o`. It also starts a division of `cfg_frame_ticks` by `cfg_height` that takes `TICK_W` further edges. No line events occur on those edges. On the last of them, the period takes the quotient and the timestamp takes `tick_i`. A write during a division restarts it.
- R6: While the height is 0, neither interrupt is raised and `cur_line_o` stays 0.
- R7: `frame_irq_o` is never high unless `line_irq_o` is high in the same cycle.
- R8: `cur_line_o` only ever holds its value, advances by one, or returns to 0, and stays below a non-zero height.
- R9: The elapsed-time comparison is modular, so line events continue at the same spacing when `tick_i` wraps past its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | TICK_W | Free-running tick count |
| cfg_we | input | 1 | Write strobe for frame length and height |
| cfg_frame_ticks | input | TICK_W | Frame length in ticks, taken on `cfg_we` |
| cfg_height | input | LINE_W | Lines per frame, taken on `cfg_we`; 0 disables |
| line_irq_o | output | 1 | One-cycle pulse per scanline |
| frame_irq_o | output | 1 | One-cycle pulse per frame wrap |
| cur_line_o | output | LINE_W | Current line number (registered) |

## Verification
Both interrupts and the line number are registered. A line event decided at an edge is therefore visible in the cycle right after that edge. The bench drives inputs at the falling edge and reads outputs at the following falling edge, so every output is compared one edge after the stimulus that caused it. A configuration write is special. It clears the line at the very next edge, and the first line event can come no sooner than `TICK_W + 1` edges later. The reference model in the bench counts the divide cycles down itself, and pulse counts are checked over windows of exactly those lengths. The wrap, step-of-three and zero-period cases are compared against the same model on every cycle.

// File: rtl/slt_pkg.sv
// Package: shared types for the scanline interrupt timer.
// Assumes nothing beyond IEEE 1800-2017.
package slt_pkg;

    // What the line sequencer does on a given edge.
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,   // nothing changes
        ACT_RESTART = 2'd1,   // configuration written: clear line, wait for divide
        ACT_ARM     = 2'd2,   // divide finished: re-arm timestamp
        ACT_LINE    = 2'd3    // line period elapsed: pulse and advance
    } slt_act_e;

endpackage

// File: rtl/slt_period_div.sv
// Module: slt_period_div
// Restoring shift-subtract divider computing line period = frame ticks / height.
// One quotient bit per cycle; a start strobe loads operands and TICK_W steps follow.
// Assumes TICK_W > LINE_W. A zero divisor yields an all-ones quotient (unused by callers).
module slt_period_div #(
    parameter int TICK_W     = 20,
    parameter int LINE_W     = 10,
    parameter int DEF_PERIOD = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TICK_W-1:0] dividend,
    input  logic [LINE_W-1:0] divisor,
    output logic              busy,
    output logic              last_step,
    output logic [TICK_W-1:0] period
);
    localparam int CNT_W = $clog2(TICK_W + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [TICK_W-1:0] quo_q;
    logic [TICK_W-1:0] dvs_q;
    logic [TICK_W:0]   rem_q;
    logic [TICK_W:0]   rem_sh;
    logic [TICK_W:0]   rem_nx;
    logic [TICK_W-1:0] quo_nx;
    logic              fits;

    // One restoring step: shift next dividend bit in, subtract if it fits.
    always_comb begin
        rem_sh = {rem_q[TICK_W-1:0], quo_q[TICK_W-1]};
        fits   = (rem_sh >= {1'b0, dvs_q});
        rem_nx = fits ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
        quo_nx = {quo_q[TICK_W-2:0], fits};
    end

    assign busy      = (cnt_q != '0);
    assign last_step = (cnt_q == CNT_W'(1));

    // Operand load, iteration, and result capture on the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            rem_q  <= '0;
            period <= TICK_W'(DEF_PERIOD);
        end else if (start) begin
            cnt_q  <= CNT_W'(TICK_W);
            quo_q  <= dividend;
            dvs_q  <= {{(TICK_W-LINE_W){1'b0}}, divisor};
            rem_q  <= '0;
        end else if (busy) begin
            cnt_q  <= cnt_q - CNT_W'(1);
            quo_q  <= quo_nx;
            rem_q  <= rem_nx;
            if (last_step) begin
                period <= quo_nx;
            end
        end
    end

endmodule

// File: rtl/slt_line_seq.sv
// Module: slt_line_seq
// Holds the height, line counter and last-event timestamp; decides each edge
// whether a line event fires and raises the line and frame pulses.
// Assumes period is stable whenever div_busy is low.
module slt_line_seq
    import slt_pkg::*;
#(
    parameter int TICK_W     = 20,
    parameter int LINE_W     = 10,
    parameter int DEF_HEIGHT = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] tick_i,
    input  logic              cfg_we,
    input  logic [LINE_W-1:0] cfg_height,
    input  logic              div_busy,
    input  logic              div_last,
    input  logic [TICK_W-1:0] period,
    output logic              line_irq,
    output logic              frame_irq,
    output logic [LINE_W-1:0] cur_line,
    output logic [LINE_W-1:0] height
);
    logic [TICK_W-1:0] last_ts_q;
    logic [TICK_W-1:0] elapsed;
    logic [LINE_W:0]   line_inc;
    logic              wrap;
    slt_act_e          act;

    // Action select: writes win, then divide progress, then the period compare.
    always_comb begin
        elapsed  = tick_i - last_ts_q;
        line_inc = {1'b0, cur_line} + (LINE_W+1)'(1);
        wrap     = (line_inc >= {1'b0, height});
        if (cfg_we) begin
            act = ACT_RESTART;
        end else if (div_busy) begin
            act = div_last ? ACT_ARM : ACT_IDLE;
        end else if ((height != '0) && (elapsed >= period)) begin
            act = ACT_LINE;
        end else begin
            act = ACT_IDLE;
        end
    end

    // State update and single-cycle pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_line  <= '0;
            height    <= LINE_W'(DEF_HEIGHT);
            last_ts_q <= tick_i;
            line_irq  <= 1'b0;
            frame_irq <= 1'b0;
        end else begin
            line_irq  <= 1'b0;
            frame_irq <= 1'b0;
            case (act)
                ACT_RESTART: begin
                    cur_line <= '0;
                    height   <= cfg_height;
                end
                ACT_ARM: begin
                    last_ts_q <= tick_i;
                end
                ACT_LINE: begin
                    line_irq  <= 1'b1;
                    last_ts_q <= tick_i;
                    if (wrap) begin
                        cur_line  <= '0;
                        frame_irq <= 1'b1;
                    end else begin
                        cur_line  <= line_inc[LINE_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/scan_irq_timer.sv
// Module: scan_irq_timer (top)
// Emulated display scan timing: per-line and per-frame interrupts derived from
// a free-running tick count, with the line period computed once per configuration write.
// Assumes TICK_W > LINE_W and that tick_i advances monotonically modulo 2^TICK_W.
module scan_irq_timer #(
    parameter int TICK_W          = 20,
    parameter int LINE_W          = 10,
    parameter int DEF_HEIGHT      = 400,
    parameter int DEF_FRAME_TICKS = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] tick_i,
    input  logic              cfg_we,
    input  logic [TICK_W-1:0] cfg_frame_ticks,
    input  logic [LINE_W-1:0] cfg_height,
    output logic              line_irq_o,
    output logic              frame_irq_o,
    output logic [LINE_W-1:0] cur_line_o
);
    localparam int DEF_PERIOD = DEF_FRAME_TICKS / DEF_HEIGHT;

    logic              div_busy_w;
    logic              div_last_w;
    logic [TICK_W-1:0] period_w;
    logic [LINE_W-1:0] height_w;

    // Period divider, started by each configuration write.
    slt_period_div #(
        .TICK_W     (TICK_W),
        .LINE_W     (LINE_W),
        .DEF_PERIOD (DEF_PERIOD)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cfg_we),
        .dividend  (cfg_frame_ticks),
        .divisor   (cfg_height),
        .busy      (div_busy_w),
        .last_step (div_last_w),
        .period    (period_w)
    );

    // Line counter, timestamp and interrupt pulses.
    slt_line_seq #(
        .TICK_W     (TICK_W),
        .LINE_W     (LINE_W),
        .DEF_HEIGHT (DEF_HEIGHT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .cfg_we     (cfg_we),
        .cfg_height (cfg_height),
        .div_busy   (div_busy_w),
        .div_last   (div_last_w),
        .period     (period_w),
        .line_irq   (line_irq_o),
        .frame_irq  (frame_irq_o),
        .cur_line   (cur_line_o),
        .height     (height_w)
    );

endmodule

// File: rtl/scan_irq_timer_chk.sv
// Module: scan_irq_timer_chk
// Property checker bound to scan_irq_timer; observes ports plus height and divide state.
module scan_irq_timer_chk #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_irq,
    input  logic              frame_irq,
    input  logic [LINE_W-1:0] cur_line,
    input  logic [LINE_W-1:0] height,
    input  logic              div_busy
);
    // R7: a frame pulse always coincides with a line pulse.
    p_frame_with_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |-> line_irq);

    // R6: no line pulse is ever produced under a zero height.
    p_zero_height_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_irq |-> (height != '0));

    // R5: no line event is decided on an edge where the divide is running.
    p_no_line_while_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |=> !line_irq);

    // R8: the line counter stays below a non-zero height.
    p_line_below_height_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (height != '0) |-> (cur_line < height));

    // R8: the line counter only advances by one or returns to zero.
    p_line_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_line) |-> ((cur_line == '0) ||
                                (cur_line == LINE_W'($past(cur_line) + 1'b1))));

    // R4: a wrap to zero during a line pulse is always flagged as a frame.
    p_wrap_is_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_irq && (cur_line == '0)) |-> frame_irq);
endmodule

bind scan_irq_timer scan_irq_timer_chk #(.LINE_W(LINE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_irq  (line_irq_o),
    .frame_irq (frame_irq_o),
    .cur_line  (cur_line_o),
    .height    (height_w),
    .div_busy  (div_busy_w)
);

// File: tb/scan_irq_timer_tb.sv
// Bench: behavioural reference model stepped once per cycle and compared every cycle.
module scan_irq_timer_tb;
    localparam int TICK_W = 20;
    localparam int LINE_W = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [TICK_W-1:0] tick_i;
    logic              cfg_we;
    logic [TICK_W-1:0] cfg_frame_ticks;
    logic [LINE_W-1:0] cfg_height;
    logic              line_irq_o;
    logic              frame_irq_o;
    logic [LINE_W-1:0] cur_line_o;

    always #2.5 clk = ~clk;

    scan_irq_timer u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick_i          (tick_i),
        .cfg_we          (cfg_we),
        .cfg_frame_ticks (cfg_frame_ticks),
        .cfg_height      (cfg_height),
        .line_irq_o      (line_irq_o),
        .frame_irq_o     (frame_irq_o),
        .cur_line_o      (cur_line_o)
    );

    // Reference model state
    logic [TICK_W-1:0] m_last;
    logic [TICK_W-1:0] m_period;
    int                m_line;
    int                m_height;
    int                m_busy;
    bit                m_li;
    bit                m_fi;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cnt_line = 0;
    int    cnt_frame = 0;
    string phase = "R1";
    bit    done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs, advance the model, then compare after the edge.
    task automatic step(input bit rst, input bit we, input int f, input int h, input int inc);
        logic [TICK_W-1:0] el;
        rst_n           = ~rst;
        cfg_we          = we;
        cfg_frame_ticks = TICK_W'(f);
        cfg_height      = LINE_W'(h);
        tick_i          = tick_i + TICK_W'(inc);
        m_li = 0;
        m_fi = 0;
        if (rst) begin
            m_line = 0; m_height = 400; m_period = 25; m_busy = 0; m_last = tick_i;
        end else if (we) begin
            m_line = 0; m_height = h; m_busy = TICK_W;
            m_period = (h == 0) ? '1 : TICK_W'(f / h);
        end else if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) m_last = tick_i;
        end else begin
            el = tick_i - m_last;
            if (m_height != 0 && el >= m_period) begin
                m_li = 1;
                m_last = tick_i;
                if (m_line + 1 >= m_height) begin
                    m_line = 0;
                    m_fi = 1;
                end else begin
                    m_line++;
                end
            end
        end
        @(negedge clk);
        check(line_irq_o === m_li, {"R2 line pulse ", phase}, int'(line_irq_o), int'(m_li));
        check(frame_irq_o === m_fi, {"R4 frame pulse ", phase}, int'(frame_irq_o), int'(m_fi));
        check(cur_line_o === LINE_W'(m_line), {"R3 line count ", phase}, int'(cur_line_o), m_line);
        if (line_irq_o === 1'b1) cnt_line++;
        if (frame_irq_o === 1'b1) cnt_frame++;
    endtask

    task automatic run(input int n, input int inc);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, inc);
    endtask

    task automatic clr();
        cnt_line = 0;
        cnt_frame = 0;
    endtask

    initial begin
        tick_i = '0;
        // R1: reset state
        phase = "R1";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1);
        check(cur_line_o == 0 && !line_irq_o && !frame_irq_o, "R1 reset state",
              int'(cur_line_o), 0);

        // R4: default configuration, one full frame of 400 lines at period 25
        phase = "R4 default";
        clr();
        run(10100, 1);
        check(cnt_frame == 1, "R4 default frame count", cnt_frame, 1);
        check(cnt_line == 404, "R3 default line count", cnt_line, 404);

        // R5: write height 5, frame 53 -> period 10; silent during divide
        phase = "R5 write";
        clr();
        step(0, 1, 53, 5, 1);
        check(cur_line_o == 0, "R5 line cleared on write", int'(cur_line_o), 0);
        run(TICK_W, 1);
        check(cnt_line == 0, "R5 quiet during divide", cnt_line, 0);
        clr();
        run(155, 1);
        check(cnt_line == 15, "R5 new period line count", cnt_line, 15);
        check(cnt_frame == 3, "R4 frames at height 5", cnt_frame, 3);

        // R2: tick advancing by 3 per cycle, event on elapsed >= period
        phase = "R2 step3";
        clr();
        run(100, 3);
        check(cnt_line == 25, "R2 step-of-3 line count", cnt_line, 25);

        // R2: zero period (frame 2, height 3) -> line every cycle, frame every third
        phase = "R2 zero period";
        step(0, 1, 2, 3, 1);
        run(TICK_W, 1);
        clr();
        run(30, 1);
        check(cnt_line == 30, "R2 zero-period line count", cnt_line, 30);
        check(cnt_frame == 10, "R7 frame with last line", cnt_frame, 10);

        // R6: height 0 disables
        phase = "R6";
        step(0, 1, 500, 0, 1);
        clr();
        run(200, 1);
        check(cnt_line == 0 && cnt_frame == 0, "R6 disabled pulses", cnt_line, 0);
        check(cur_line_o == 0, "R6 line held at zero", int'(cur_line_o), 0);

        // R5: write during divide restarts it (height 7, frame 70 -> period 10)
        phase = "R5 restart";
        clr();
        step(0, 1, 100, 4, 1);
        run(5, 1);
        step(0, 1, 70, 7, 1);
        run(TICK_W, 1);
        check(cnt_line == 0, "R5 quiet through restarted divide", cnt_line, 0);
        clr();
        run(75, 1);
        check(cnt_line == 7, "R5 restarted period line count", cnt_line, 7);
        check(cnt_frame == 1, "R4 frame at height 7", cnt_frame, 1);

        // R9: tick wraps past its maximum
        phase = "R9 wrap";
        tick_i = '1 - TICK_W'(35);
        step(0, 0, 0, 0, 0);
        clr();
        run(80, 1);
        check(cnt_line == 8, "R9 spacing across wrap", cnt_line, 8);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule